// File: doc/BRIEF.md
# Packet Buffer Byte-Lane Data Port

This block sits between a 16-bit host register bus and a byte-wide packet buffer memory. The host loads a 16-bit pointer register and a packet-number register, then moves data through a data port. The low 11 bits of the pointer give the byte offset within the selected buffer. The low bits of the packet number pick the buffer. Bit 14 of the pointer turns on auto-increment.

Each data-port access carries two lane enables. Only the enabled lanes move a byte, the low lane first, and the byte offset advances once for each byte moved. An 8-bit host and a 16-bit host therefore walk the same buffer in the same byte order, and they can be interleaved freely. Reads return their result one cycle after the access. A small synchronous byte RAM stands in for the real buffer storage.

Top module: `pb_data_port`

## Requirements
- R1: After reset `ptr_o` is 0, `pkt_o` is 0 and `rvalid_o` is 0.
- R2: A cycle with `ptr_we_i` high loads `ptr_wdata_i` into the pointer. A cycle with `pkt_we_i` high loads `pkt_wdata_i` into the packet number. The buffer index is the packet number modulo NUM_BUF, so packet numbers 1 and 5 select the same buffer when NUM_BUF is 4.
- R3: The byte offset is `ptr_o[10:0]`. Within the selected buffer, a byte lives at that offset modulo BUF_BYTES.
- R4: A write with only the low lane enabled (`lane_en_i` = 2'b01) stores `wdata_i[7:0]` at the offset. A write with only the high lane enabled (2'b10) stores `wdata_i[15:8]` at the offset.
- R5: A write with both lanes enabled stores `wdata_i[7:0]` at the offset and `wdata_i[15:8]` at offset+1.
- R6: A read returns its data on `rdata_o` in the next cycle, with `rvalid_o` high. The low lane carries the byte at the offset. The high lane carries the byte after the low lane's byte, or the byte at the offset if it is the only lane enabled. A disabled lane reads as zero.
- R7: When pointer bit 14 is set, an access moves the offset forward by the number of enabled lanes, modulo 2048. Pointer bits [15:11] are left unchanged.
- R8: When pointer bit 14 is clear, accesses leave the pointer unchanged.
- R9: An access with `lane_en_i` = 2'b00 moves no byte, raises no `rvalid_o` and leaves the pointer unchanged.
- R10: When `ptr_we_i` and an access fall in the same cycle, the access uses the old pointer and the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_we_i | input | 1 | Load the pointer register |
| ptr_wdata_i | input | 16 | New pointer value |
| pkt_we_i | input | 1 | Load the packet-number register |
| pkt_wdata_i | input | 5 | New packet number |
| acc_i | input | 1 | Data-port access strobe |
| acc_wr_i | input | 1 | 1 for a write access, 0 for a read access |
| lane_en_i | input | 2 | Lane enables: bit 0 is the low byte, bit 1 is the high byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, one cycle after the access |
| rvalid_o | output | 1 | Read data is valid |
| ptr_o | output | 16 | Current pointer register |
| pkt_o | output | 5 | Current packet-number register |

## Verification
The assertions assume that every input is known and stable at the clock edge. They also assume that the two lane addresses of one access never fall on the same RAM byte, which holds whenever BUF_BYTES is at least 2. The bench drives all inputs on the falling edge and drops the access strobe right after the rising edge. It fills every buffer before it reads anything, so every read hits a known byte. It tests the same-cycle pointer load only as a deliberate case.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int PTR_W    = 16;
  localparam int OFF_W    = 11;
  localparam int AUTO_BIT = 14;
  localparam int PKT_W    = 5;
endpackage

// File: rtl/pb_addr_gen.sv
module pb_addr_gen
  import pb_pkg::*;
(
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [1:0]       lane_en_i,
  output logic [OFF_W-1:0] lo_off_o,
  output logic [OFF_W-1:0] hi_off_o,
  output logic [PTR_W-1:0] ptr_adv_o
);
  logic [OFF_W-1:0] base;
  logic [OFF_W-1:0] nxt;

  always_comb begin
    base     = ptr_i[OFF_W-1:0];
    lo_off_o = base;
    // the high lane follows the low lane only when the low lane moved a byte
    hi_off_o = base + {{(OFF_W-1){1'b0}}, lane_en_i[0]};
    nxt      = hi_off_o + {{(OFF_W-1){1'b0}}, lane_en_i[1]};
    ptr_adv_o = {ptr_i[PTR_W-1:OFF_W], nxt};
  end
endmodule

// File: rtl/pb_byte_ram.sv
module pb_byte_ram #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [7:0]    a_wdata_i,
  output logic [7:0]    a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [7:0]    b_wdata_i,
  output logic [7:0]    b_rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (a_en_i) begin
      if (a_we_i) mem[a_addr_i] <= a_wdata_i;
      else        a_rdata_o     <= mem[a_addr_i];
    end
    if (b_en_i) begin
      if (b_we_i) mem[b_addr_i] <= b_wdata_i;
      else        b_rdata_o     <= mem[b_addr_i];
    end
  end
endmodule

// File: rtl/pb_lane_pack.sv
module pb_lane_pack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic [1:0]  lane_en_i,
  input  logic [7:0]  lo_byte_i,
  input  logic [7:0]  hi_byte_i,
  output logic [15:0] rdata_o,
  output logic        rvalid_o
);
  logic [1:0] lane_q;
  logic       rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q   <= 2'b00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i && (lane_en_i != 2'b00);
      if (rd_i) lane_q <= lane_en_i;
    end
  end

  always_comb begin
    rdata_o  = '0;
    if (rvalid_q && lane_q[0]) rdata_o[7:0]  = lo_byte_i;
    if (rvalid_q && lane_q[1]) rdata_o[15:8] = hi_byte_i;
    rvalid_o = rvalid_q;
  end

  a_r6_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && lane_en_i != 2'b00) |=> rvalid_o);
  a_r6_idle_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !lane_en_i[1]) |=> (rdata_o[15:8] == 8'h00));
  a_r9_no_lane_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && lane_en_i == 2'b00) |=> !rvalid_o);
endmodule

// File: rtl/pb_data_port.sv
module pb_data_port
  import pb_pkg::*;
#(
  parameter int NUM_BUF   = 4,
  parameter int BUF_BYTES = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ptr_we_i,
  input  logic [15:0] ptr_wdata_i,
  input  logic        pkt_we_i,
  input  logic [4:0]  pkt_wdata_i,
  input  logic        acc_i,
  input  logic        acc_wr_i,
  input  logic [1:0]  lane_en_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        rvalid_o,
  output logic [15:0] ptr_o,
  output logic [4:0]  pkt_o
);
  localparam int IDX_W = $clog2(NUM_BUF);
  localparam int BA_W  = $clog2(BUF_BYTES);
  localparam int RAM_D = NUM_BUF * BUF_BYTES;

  logic [PTR_W-1:0] ptr_q;
  logic [PKT_W-1:0] pkt_q;
  logic [OFF_W-1:0] lo_off, hi_off;
  logic [PTR_W-1:0] ptr_adv;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rd_lo, rd_hi;
  logic             moved;

  assign idx   = pkt_q[IDX_W-1:0];
  assign moved = acc_i && (lane_en_i != 2'b00);

  pb_addr_gen u_addr (
    .ptr_i     (ptr_q),
    .lane_en_i (lane_en_i),
    .lo_off_o  (lo_off),
    .hi_off_o  (hi_off),
    .ptr_adv_o (ptr_adv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      pkt_q <= '0;
    end else begin
      if (ptr_we_i)                      ptr_q <= ptr_wdata_i;
      else if (moved && ptr_q[AUTO_BIT]) ptr_q <= ptr_adv;
      if (pkt_we_i) pkt_q <= pkt_wdata_i;
    end
  end

  pb_byte_ram #(.DEPTH(RAM_D)) u_ram (
    .clk_i     (clk_i),
    .a_en_i    (acc_i && lane_en_i[0]),
    .a_we_i    (acc_wr_i),
    .a_addr_i  ({idx, lo_off[BA_W-1:0]}),
    .a_wdata_i (wdata_i[7:0]),
    .a_rdata_o (rd_lo),
    .b_en_i    (acc_i && lane_en_i[1]),
    .b_we_i    (acc_wr_i),
    .b_addr_i  ({idx, hi_off[BA_W-1:0]}),
    .b_wdata_i (wdata_i[15:8]),
    .b_rdata_o (rd_hi)
  );

  pb_lane_pack u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (acc_i && !acc_wr_i),
    .lane_en_i (lane_en_i),
    .lo_byte_i (rd_lo),
    .hi_byte_i (rd_hi),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign ptr_o = ptr_q;
  assign pkt_o = pkt_q;

  a_r7_upper_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_we_i) |=> (ptr_o[15:11] == $past(ptr_o[15:11])));
  a_r7_two_lane_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_we_i && acc_i && ptr_o[14] && lane_en_i == 2'b11)
      |=> (ptr_o[10:0] == $past(ptr_o[10:0]) + 11'd2));
  a_r7_one_lane_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_we_i && acc_i && ptr_o[14] && $countones(lane_en_i) == 1)
      |=> (ptr_o[10:0] == $past(ptr_o[10:0]) + 11'd1));
  a_r8_no_auto_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_we_i && !ptr_o[14]) |=> $stable(ptr_o));
  a_r9_idle_lanes_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_we_i && lane_en_i == 2'b00) |=> $stable(ptr_o));
  a_r10_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i |=> (ptr_o == $past(ptr_wdata_i)));
endmodule

// File: tb/tb_pb_data_port.sv
module tb_pb_data_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptr_we_i = 0, pkt_we_i = 0, acc_i = 0, acc_wr_i = 0;
  logic [15:0] ptr_wdata_i = 0, wdata_i = 0;
  logic [4:0]  pkt_wdata_i = 0;
  logic [1:0]  lane_en_i = 0;
  logic [15:0] rdata_o, ptr_o;
  logic        rvalid_o;
  logic [4:0]  pkt_o;

  int checks = 0, errors = 0;
  logic [7:0]  mm [0:1023];
  logic [15:0] m_ptr = 0;
  logic [4:0]  m_pkt = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  pb_data_port dut (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int maddr(input logic [10:0] off);
    return int'(m_pkt & 5'd3) * 256 + int'(off & 11'h0ff);
  endfunction

  task automatic set_ptr(input logic [15:0] v);
    @(negedge clk); ptr_we_i = 1; ptr_wdata_i = v;
    @(posedge clk); #1 ptr_we_i = 0; m_ptr = v;
    chk(ptr_o === v, "R2 ptr load", ptr_o, v);
  endtask

  task automatic set_pkt(input logic [4:0] v);
    @(negedge clk); pkt_we_i = 1; pkt_wdata_i = v;
    @(posedge clk); #1 pkt_we_i = 0; m_pkt = v;
    chk(pkt_o === v, "R2 pkt load", pkt_o, v);
  endtask

  // one data-port access with an optional same-cycle pointer load
  task automatic acc(input bit wr, input logic [1:0] ln, input logic [15:0] wd,
                     input bit ld, input logic [15:0] ldv, input string req);
    logic [10:0] off;
    logic [15:0] exp;
    int n;
    @(negedge clk);
    acc_i = 1; acc_wr_i = wr; lane_en_i = ln; wdata_i = wd;
    ptr_we_i = ld; ptr_wdata_i = ldv;
    off = m_ptr[10:0]; exp = 16'h0000; n = 0;
    if (ln[0]) begin
      if (wr) mm[maddr(off)] = wd[7:0]; else exp[7:0] = mm[maddr(off)];
      off = off + 11'd1; n++;
    end
    if (ln[1]) begin
      if (wr) mm[maddr(off)] = wd[15:8]; else exp[15:8] = mm[maddr(off)];
      off = off + 11'd1; n++;
    end
    if (ld) m_ptr = ldv;
    else if (m_ptr[14] && n > 0) m_ptr = {m_ptr[15:11], off};
    @(posedge clk); #1;
    acc_i = 0; ptr_we_i = 0;
    chk(ptr_o === m_ptr, {req, " ptr"}, ptr_o, m_ptr);
    if (!wr && ln != 2'b00) begin
      chk(rvalid_o === 1'b1, {req, " R6 rvalid"}, rvalid_o, 1);
      chk(rdata_o === exp, {req, " R6 rdata"}, rdata_o, exp);
    end else
      chk(rvalid_o === 1'b0, {req, " R9 no rvalid"}, rvalid_o, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(ptr_o === 16'h0 && pkt_o === 5'h0 && rvalid_o === 1'b0, "R1 reset", {ptr_o, 11'b0, pkt_o}, 0);
    rst_ni = 1;

    // fill every buffer with 16-bit auto-increment writes (R5, R7)
    for (int b = 0; b < 4; b++) begin
      set_pkt(5'(b));
      set_ptr(16'h4000);
      for (int i = 0; i < 128; i++)
        acc(1, 2'b11, 16'(b * 4096 + i * 7 + 16'h0301), 0, 0, "R5 fill");
    end

    // mixed 8/16-bit writes then reads on packet 1 (R4, R5, R6, R7)
    set_pkt(5'd1);
    set_ptr(16'h4010);
    acc(1, 2'b11, 16'hbbaa, 0, 0, "R5 wr16");
    acc(1, 2'b01, 16'hee11, 0, 0, "R4 wr lo");
    acc(1, 2'b10, 16'h22ee, 0, 0, "R4 wr hi");
    acc(1, 2'b11, 16'h4433, 0, 0, "R5 wr16b");
    chk(ptr_o === 16'h4016, "R7 mixed step", ptr_o, 16'h4016);
    set_ptr(16'h4010);
    acc(0, 2'b11, 0, 0, 0, "R6 rd16");
    chk(rdata_o === 16'hbbaa, "R5 byte order", rdata_o, 16'hbbaa);
    acc(0, 2'b01, 0, 0, 0, "R6 rd lo");
    chk(rdata_o === 16'h0011, "R4 lo byte", rdata_o, 16'h0011);
    acc(0, 2'b10, 0, 0, 0, "R6 rd hi");
    chk(rdata_o === 16'h2200, "R4 hi byte", rdata_o, 16'h2200);
    acc(0, 2'b01, 0, 0, 0, "R6 rd lo2");
    chk(rdata_o === 16'h0033, "R6 split", rdata_o, 16'h0033);
    acc(0, 2'b10, 0, 0, 0, "R6 rd hi2");
    chk(rdata_o === 16'h4400, "R6 split hi", rdata_o, 16'h4400);

    // offset wrap with upper bits kept (R3, R7)
    set_ptr(16'hc7ff);
    acc(1, 2'b11, 16'h5aa5, 0, 0, "R7 wrap wr");
    chk(ptr_o === 16'hc001, "R7 wrap ptr", ptr_o, 16'hc001);
    set_ptr(16'h40ff);
    acc(0, 2'b11, 0, 0, 0, "R3 alias rd");
    chk(rdata_o === 16'h5aa5, "R3 offset mod", rdata_o, 16'h5aa5);

    // no auto-increment (R8) and no lanes (R9)
    set_ptr(16'h0020);
    acc(1, 2'b11, 16'h7788, 0, 0, "R8 wr");
    acc(0, 2'b11, 0, 0, 0, "R8 rd");
    chk(rdata_o === 16'h7788 && ptr_o === 16'h0020, "R8 hold", {rdata_o, ptr_o}, {16'h7788, 16'h0020});
    set_ptr(16'h4030);
    acc(1, 2'b00, 16'hffff, 0, 0, "R9 wr none");
    acc(0, 2'b00, 0, 0, 0, "R9 rd none");
    chk(ptr_o === 16'h4030, "R9 ptr", ptr_o, 16'h4030);

    // packet index aliasing (R2) and load wins (R10)
    set_pkt(5'd5);
    set_ptr(16'h4010);
    acc(0, 2'b11, 0, 0, 0, "R2 alias rd");
    chk(rdata_o === 16'hbbaa, "R2 pkt mod", rdata_o, 16'hbbaa);
    acc(1, 2'b11, 16'h9966, 1, 16'h4100, "R10 load wins");
    chk(ptr_o === 16'h4100, "R10 ptr", ptr_o, 16'h4100);

    // random mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) set_pkt(5'($urandom));
      else if (r < 10) set_ptr(16'($urandom) & 16'hc7ff | (r < 8 ? 16'h4000 : 16'h0));
      else acc(1'($urandom), 2'($urandom), 16'($urandom), 0, 0, "R7 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule